// File: doc/BRIEF.md
# Feed-Forward Programmable Logic Fabric

This block is a small synthesizable array of configurable logic that a chip can carry so that part of its function can be changed after fabrication. The array is arranged as columns of three-input lookup-table cells. Each cell picks its three inputs from the fabric's primary inputs or from the cells of the column just to its left. Signals therefore only travel rightward, so every configuration is a pure combinational function and no combinational loop can be built. A final rank of output selectors connects each primary output to a primary input or to a cell of the rightmost column.

All truth tables and selector codes sit in one serial configuration register, loaded one bit per enabled clock. The outputs stay at zero until a full chain length has been shifted in since reset, and they are forced to zero whenever shifting is enabled, so a half-written setup never reaches the surrounding logic. The grid may be trimmed toward a triangle: the rightmost column loses `TRIM` cells and each column to its left loses one fewer. Trimmed cells have no logic and no configuration bits.

Top module: `dir_logic_fabric`

## Requirements
- R1: While `rst_n` is low the configuration register and the shift count are cleared; after reset, with `cfg_en` low, `pout` is zero for every `pin`.
- R2: `pout` stays zero until at least the full chain length (CHAIN_LEN bits) has been shifted in since reset; from then on it follows the configured function.
- R3: Whenever `cfg_en` is high, `pout` is zero in that same cycle, whatever `pin` and the configuration are.
- R4: Each rising `cfg_clk` edge with `cfg_en` high shifts `cfg_data` in at the top of the chain and moves every bit down one place; the first of CHAIN_LEN shifted bits ends at chain position 0. With `cfg_en` low the chain holds.
- R5: Each cell drives bit `{in2,in1,in0}` of its 8-bit truth table. A cell occupies 8+3*SELW chain bits: truth table in the lowest 8, then the select codes for in0, in1, in2, each SELW bits wide (SELW = clog2(NUM_IN+ROWS)).
- R6: A cell select code k below NUM_IN picks `pin[k]`; code NUM_IN+r picks row r of the previous column. Cells of column 0 see zero for any code of NUM_IN or above.
- R7: Output o takes its SELW-bit code at chain position (cell bits)+o*SELW; code k below NUM_IN picks `pin[k]`, code NUM_IN+r picks row r of the last column.
- R8: Column c holds ROWS-max(0, TRIM-(COLS-1-c)) cells (rows 0 upward), stored column by column from column 0, row by row. A code naming a trimmed cell reads zero.
- R9: The path from `pin` to `pout` has no storage: `pout` reflects a new `pin` in the same cycle, and with configuration and `pin` unchanged `pout` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_en | input | 1 | Shift enable for the configuration chain; masks the outputs |
| cfg_data | input | 1 | Serial configuration bit |
| pin | input | NUM_IN | Primary inputs of the fabric |
| pout | output | NUM_OUT | Primary outputs of the fabric |

## Verification
The two functions that meet in one cycle are live evaluation of `pin` and a configuration shift: the bench raises `cfg_en` in the very cycle it presents an input that the loaded function maps to a nonzero value, and expects zero at the ports before the shifting edge. It also splits a load one bit short of the chain length, checks that outputs stay at zero with a pattern whose final result would be nonzero, then shifts the last bit and checks the full function. Random configurations on a trimmed grid are compared with an independent model over all input combinations.

// File: rtl/fabric_pkg.sv
package fabric_pkg;

  // Cells kept in column c after triangular trimming.
  function automatic int rows_in(input int rows, input int cols, input int trim, input int c);
    int cut;
    cut = trim - (cols - 1 - c);
    if (cut < 0) cut = 0;
    return rows - cut;
  endfunction

  // Number of cells in all columns left of column c.
  function automatic int cells_before(input int rows, input int cols, input int trim, input int c);
    int n;
    n = 0;
    for (int k = 0; k < c; k++) n += rows_in(rows, cols, trim, k);
    return n;
  endfunction

endpackage

// File: rtl/src_mux.sv
module src_mux #(
  parameter int NSRC = 8,
  parameter int SELW = 3
) (
  input  logic [NSRC-1:0] src,
  input  logic [SELW-1:0] sel,
  output logic            y
);
  always_comb begin
    y = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel == SELW'(i)) y = src[i];
    end
  end
endmodule

// File: rtl/lut_cell.sv
module lut_cell #(
  parameter int NSRC = 8,
  parameter int SELW = 3,
  localparam int CELL_BITS = 8 + 3 * SELW
) (
  input  logic [NSRC-1:0]      src,
  input  logic [CELL_BITS-1:0] cfg,
  output logic                 y
);
  logic [7:0] truth;
  logic [2:0] idx;

  assign truth = cfg[7:0];

  for (genvar k = 0; k < 3; k++) begin : g_in
    src_mux #(.NSRC(NSRC), .SELW(SELW)) u_mux (
      .src(src),
      .sel(cfg[8 + k*SELW +: SELW]),
      .y  (idx[k])
    );
  end

  assign y = truth[idx];
endmodule

// File: rtl/cfg_chain.sv
module cfg_chain #(
  parameter int LEN = 64,
  localparam int CW = $clog2(LEN + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           din,
  output logic [LEN-1:0] q,
  output logic           loaded
);
  logic [LEN-1:0] q_d;
  logic [CW-1:0]  cnt_q, cnt_d;

  always_comb begin
    q_d   = q;
    cnt_d = cnt_q;
    if (shift_en) begin
      q_d = {din, q[LEN-1:1]};
      if (cnt_q != CW'(LEN)) cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      cnt_q <= '0;
    end else begin
      q     <= q_d;
      cnt_q <= cnt_d;
    end
  end

  assign loaded = (cnt_q == CW'(LEN));

  // R4
  chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(q));

  // R2
  load_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> loaded);
endmodule

// File: rtl/dir_logic_fabric.sv
module dir_logic_fabric
  import fabric_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4,
  parameter int COLS    = 4,
  parameter int ROWS    = 4,
  parameter int TRIM    = 0
) (
  input  logic               cfg_clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic               cfg_data,
  input  logic [NUM_IN-1:0]  pin,
  output logic [NUM_OUT-1:0] pout
);
  localparam int NSRC      = NUM_IN + ROWS;
  localparam int SELW      = $clog2(NSRC);
  localparam int CELL_BITS = 8 + 3 * SELW;
  localparam int NCELLS    = cells_before(ROWS, COLS, TRIM, COLS);
  localparam int OUT_BASE  = NCELLS * CELL_BITS;
  localparam int CHAIN_LEN = OUT_BASE + NUM_OUT * SELW;

  logic [CHAIN_LEN-1:0]       cfg_bits;
  logic                       loaded;
  logic [COLS-1:0][ROWS-1:0]  col_y;
  logic [NUM_OUT-1:0]         route;
  logic [NSRC-1:0]            out_src;

  cfg_chain #(.LEN(CHAIN_LEN)) u_chain (
    .clk     (cfg_clk),
    .rst_n   (rst_n),
    .shift_en(cfg_en),
    .din     (cfg_data),
    .q       (cfg_bits),
    .loaded  (loaded)
  );

  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam int RC   = rows_in(ROWS, COLS, TRIM, c);
    localparam int BASE = cells_before(ROWS, COLS, TRIM, c) * CELL_BITS;
    logic [NSRC-1:0] src;

    if (c == 0) begin : g_first
      assign src = {{ROWS{1'b0}}, pin};
    end else begin : g_next
      assign src = {col_y[c-1], pin};
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
      if (r < RC) begin : g_cell
        lut_cell #(.NSRC(NSRC), .SELW(SELW)) u_cell (
          .src(src),
          .cfg(cfg_bits[BASE + r*CELL_BITS +: CELL_BITS]),
          .y  (col_y[c][r])
        );
      end else begin : g_trim
        assign col_y[c][r] = 1'b0;
      end
    end
  end

  assign out_src = {col_y[COLS-1], pin};

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    src_mux #(.NSRC(NSRC), .SELW(SELW)) u_omux (
      .src(out_src),
      .sel(cfg_bits[OUT_BASE + o*SELW +: SELW]),
      .y  (route[o])
    );
  end

  assign pout = (loaded && !cfg_en) ? route : '0;

  // R3
  cfg_mask_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    cfg_en |-> pout == '0);

  // R2
  unloaded_zero_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !loaded |-> pout == '0);

  // R9
  comb_hold_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (!cfg_en && $past(!cfg_en) && $stable(pin)) |-> $stable(pout));
endmodule

// File: tb/dir_logic_fabric_test.sv
`timescale 1ns/1ps
module dir_logic_fabric_test;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int C  = 4;
  localparam int R  = 4;
  localparam int T  = 2;
  localparam int SW = 3;
  localparam int CB = 8 + 3 * SW;

  function automatic int col_rows(input int c);
    int cut;
    cut = T - (C - 1 - c);
    return (cut > 0) ? R - cut : R;
  endfunction

  function automatic int col_base(input int c);
    int n;
    n = 0;
    for (int k = 0; k < c; k++) n += col_rows(k) * CB;
    return n;
  endfunction

  localparam int OB  = col_base(C);
  localparam int LEN = OB + NO * SW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_en;
  logic          cfg_data;
  logic [NI-1:0] pin;
  logic [NO-1:0] pout;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [NO-1:0] exp_q[$];
  string         tag_q[$];
  logic [LEN-1:0] cv;

  always #2.5 clk = ~clk;

  dir_logic_fabric #(.NUM_IN(NI), .NUM_OUT(NO), .COLS(C), .ROWS(R), .TRIM(T)) uut (
    .cfg_clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_data(cfg_data),
    .pin(pin), .pout(pout)
  );

  // Independent model of the configured netlist.
  function automatic logic [NO-1:0] model(input logic [LEN-1:0] v, input logic [NI-1:0] p);
    logic [R-1:0]  prev, cur;
    logic [2:0]    ix;
    logic [NO-1:0] res;
    int s, b;
    prev = '0;
    for (int c = 0; c < C; c++) begin
      cur = '0;
      for (int r = 0; r < col_rows(c); r++) begin
        b = col_base(c) + r * CB;
        for (int k = 0; k < 3; k++) begin
          s = int'(v[b + 8 + k*SW +: SW]);
          if (s < NI)               ix[k] = p[s];
          else if (c > 0 && s-NI < R) ix[k] = prev[s-NI];
          else                      ix[k] = 1'b0;
        end
        cur[r] = v[b + int'(ix)];
      end
      prev = cur;
    end
    for (int o = 0; o < NO; o++) begin
      s = int'(v[OB + o*SW +: SW]);
      if (s < NI)        res[o] = p[s];
      else if (s-NI < R) res[o] = prev[s-NI];
      else               res[o] = 1'b0;
    end
    return res;
  endfunction

  task automatic set_cell(input int c, input int r, input logic [7:0] tt,
                          input int s0, input int s1, input int s2);
    int b;
    b = col_base(c) + r * CB;
    cv[b +: 8]          = tt;
    cv[b + 8 +: SW]     = SW'(s0);
    cv[b + 8 + SW +: SW]   = SW'(s1);
    cv[b + 8 + 2*SW +: SW] = SW'(s2);
  endtask

  task automatic set_out(input int o, input int s);
    cv[OB + o*SW +: SW] = SW'(s);
  endtask

  task automatic shift_bits(input int from, input int to);
    @(posedge clk); #1;
    for (int i = from; i < to; i++) begin
      cfg_en = 1'b1;
      cfg_data = cv[i];
      @(posedge clk); #1;
    end
    cfg_en = 1'b0;
  endtask

  task automatic apply(input logic [NI-1:0] v, input logic [NO-1:0] e, input string t);
    @(posedge clk); #1;
    pin = v;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic sweep(input string t);
    for (int v = 0; v < (1 << NI); v++) apply(NI'(v), model(cv, NI'(v)), t);
  endtask

  // Monitor: compares one expected item per cycle, away from the active edge.
  always @(negedge clk) begin
    logic [NO-1:0] e;
    string t;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (pout !== e) begin
        errors++;
        $display("FAIL %s: pout=%b expected=%b", t, pout, e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_en = 1'b0; cfg_data = 1'b0; pin = '0; cv = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: cleared state, outputs zero.
    apply('1, '0, "R1 reset");
    apply(4'h5, '0, "R1 reset");

    // R2 / R7: outputs pass primary inputs straight through once loaded.
    cv = '0;
    for (int o = 0; o < NO; o++) set_out(o, o);
    shift_bits(0, LEN - 1);
    apply(4'hF, '0, "R2 short load");
    apply(4'h9, '0, "R2 short load");
    shift_bits(LEN - 1, LEN);
    apply(4'hF, 4'hF, "R2 full load");
    apply(4'h6, 4'h6, "R7 pin route");

    // R3: shift enabled in the same cycle as a live input.
    @(posedge clk); #1;
    cfg_en = 1'b1; cfg_data = 1'b0; pin = 4'hF;
    exp_q.push_back('0); tag_q.push_back("R3 mask during shift");
    @(posedge clk); #1;
    cfg_en = 1'b0;

    // R6 / R4: in0 of row 0 chained through every column (truth AA = in0).
    cv = '0;
    set_cell(0, 0, 8'hAA, 0, 0, 0);
    for (int c = 1; c < C; c++) set_cell(c, 0, 8'hAA, NI + 0, 0, 0);
    set_out(0, NI + 0);
    for (int o = 1; o < NO; o++) set_out(o, o);
    shift_bits(0, LEN);
    apply(4'h1, 4'h1, "R6 chain one");
    apply(4'hE, 4'hE, "R6 chain zero");
    apply(4'h7, 4'h7, "R4 layout");

    // R6: column 0 reading a previous-column code sees zero.
    set_cell(0, 0, 8'hAA, NI + 0, 0, 0);
    shift_bits(0, LEN);
    apply(4'h1, 4'h0, "R6 col0 prev code");
    apply(4'hF, 4'hE, "R6 col0 prev code");

    // R8: all truth tables one; trimmed rows of last column read zero.
    cv = '0;
    for (int c = 0; c < C; c++)
      for (int r = 0; r < col_rows(c); r++) set_cell(c, r, 8'hFF, 0, 1, 2);
    for (int o = 0; o < NO; o++) set_out(o, NI + o);
    shift_bits(0, LEN);
    apply(4'h0, 4'b0011, "R8 trimmed rows");
    apply(4'hA, 4'b0011, "R8 trimmed rows");

    // R5 R6 R7 R9: random configurations, every input combination.
    for (int n = 0; n < 8; n++) begin
      for (int i = 0; i < LEN; i++) cv[i] = 1'($urandom());
      shift_bits(0, LEN);
      sweep("R5 R6 R7 R9 random");
    end

    // R1: a second reset clears the load state.
    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    apply('1, '0, "R1 re-reset");

    @(posedge clk); @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule